// File: doc/BRIEF.md
# PWM Fault Flag and Automatic Disable

This block sits between the fault input filters and the PWM output stage of a motor-control timer. It takes one filtered fault level and one qualified rising-edge pulse per channel. From these it keeps a readable level mirror, a sticky event flag and an interrupt latch for each channel. It also drives one PWM disable line per channel in automatic recovery mode. A fault forces its disable line high at once. The line stays high after the fault has gone and is released only at a PWM period boundary where the fault is low. Acknowledging the event flag does not release it.

Software reaches the block through a one-cycle write port. The write carries a select code and a data vector with one bit per channel. It can acknowledge flags (write-one-to-clear) or load the interrupt-enable bits. A write aimed at the level mirror is accepted and has no effect. The interrupt request is the OR of the per-channel interrupt latches.

Top module: `pwm_fault_guard`

## Requirements
- R1: `pwm_dis[i]` is high in every cycle where `flt_lvl[i]` is high, including the first cycle of the fault, with no register delay.
- R2: Once set by a fault, `pwm_dis[i]` stays high after `flt_lvl[i]` falls. It goes low only in the cycle after a cycle in which `period_start` is high and `flt_lvl[i]` is low. A `period_start` pulse while the fault is still high does not release it.
- R3: Acknowledging channel i's flag has no effect on `pwm_dis[i]`.
- R4: `lvl_rd` equals `flt_lvl` delayed by one cycle. A write with `reg_sel` = 2 (level field) changes no output and no state. A write with `reg_sel` = 3 (reserved) also changes no output and no state.
- R5: `flag_rd[i]` is set in the cycle after `flt_rise[i]` is high and stays set. It clears in the cycle after a write with `reg_sel` = 0 (acknowledge) where `reg_wdata[i]` = 1. Acknowledge bits that are 0 leave their flags unchanged.
- R6: If an acknowledge of channel i coincides with `flt_rise[i]`, the flag stays set.
- R7: A write with `reg_sel` = 1 loads `ien_rd` from `reg_wdata` in the next cycle. A `flt_rise[i]` in a cycle where channel i's enable (the value being written that cycle, else the held one) is 1 sets channel i's interrupt latch. `irq` is the OR of all latches and shows the latch state from the same cycle.
- R8: Channel i's interrupt latch clears on an acknowledge of channel i or when its enable bit is written to 0. Clearing the enable leaves `flag_rd[i]` set.
- R9: Synchronous reset clears all flags, enable bits, interrupt latches, disable holds and `lvl_rd`, so `irq` is low and `pwm_dis` follows only `flt_lvl`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_lvl | input | NCH | Filtered fault level per channel |
| flt_rise | input | NCH | Qualified rising-edge pulse per channel |
| period_start | input | 1 | Pulse at the start of each PWM period |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Write target: 0 acknowledge, 1 enable, 2 level (ignored), 3 reserved |
| reg_wdata | input | NCH | Write data, one bit per channel |
| pwm_dis | output | NCH | PWM disable per channel |
| lvl_rd | output | NCH | Read-back of the fault level |
| flag_rd | output | NCH | Read-back of the sticky event flags |
| ien_rd | output | NCH | Read-back of the interrupt-enable bits |
| irq | output | 1 | Interrupt request |

## Verification
The bench checks the disable line combinationally in the very cycle a fault arrives. A design that registers the disable would leave the output stage running for one cycle of a fault. It acknowledges a flag while the disable is held and while the fault is still high. A design that tied recovery to the flag would release the outputs early. It also pulses the period boundary while the fault is still active. The bench hits an acknowledge that coincides with a new edge, where a design with the wrong priority would lose the event. It clears an enable bit, which must drop the request yet keep the flag. Writes to the level field must not disturb any state, and a mid-run reset must wipe the latches.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
  typedef enum logic [1:0] {
    SEL_ACK = 2'd0,
    SEL_IEN = 2'd1,
    SEL_LVL = 2'd2,
    SEL_RSV = 2'd3
  } pfg_sel_e;
endpackage

// File: rtl/pfg_regfile.sv
// Write decode and the interrupt-enable register.
module pfg_regfile #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [1:0]     reg_sel,
  input  logic [NCH-1:0] reg_wdata,
  output logic [NCH-1:0] ack_vec,
  output logic [NCH-1:0] ien_next,
  output logic [NCH-1:0] ien_q
);
  import pfg_pkg::*;

  pfg_sel_e sel;
  logic     wr_ack;
  logic     wr_ien;

  always_comb begin
    sel    = pfg_sel_e'(reg_sel);
    wr_ack = reg_wr && (sel == SEL_ACK);
    wr_ien = reg_wr && (sel == SEL_IEN);
    // level-field and reserved writes fall through with no decode
    ack_vec  = wr_ack ? reg_wdata : '0;
    ien_next = wr_ien ? reg_wdata : ien_q;
  end

  always_ff @(posedge clk) begin
    if (rst) ien_q <= '0;
    else     ien_q <= ien_next;
  end
endmodule

// File: rtl/pfg_chan.sv
// One fault channel: level mirror, disable hold, sticky flag, interrupt latch.
module pfg_chan (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic rise,
  input  logic period_start,
  input  logic ack,
  input  logic ien_next,
  output logic dis,
  output logic lvl_q,
  output logic flag_q,
  output logic latch_d,
  output logic latch_q
);
  logic hold_q;
  logic hold_d;
  logic flag_d;
  logic latch_set;
  logic latch_clr;

  always_comb begin
    // the hold re-arms while the fault is high, drops only at a period edge
    hold_d    = lvl | (hold_q & ~period_start);
    // a new edge has priority over the acknowledge
    flag_d    = rise | (flag_q & ~ack);
    latch_set = rise & ien_next;
    latch_clr = ack | ~ien_next;
    latch_d   = latch_set | (latch_q & ~latch_clr);
    // the disable must react in the fault's own cycle
    dis       = lvl | hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q  <= 1'b0;
      flag_q  <= 1'b0;
      latch_q <= 1'b0;
      lvl_q   <= 1'b0;
    end else begin
      hold_q  <= hold_d;
      flag_q  <= flag_d;
      latch_q <= latch_d;
      lvl_q   <= lvl;
    end
  end
endmodule

// File: rtl/pfg_irq.sv
// Registered OR of the per-channel interrupt latches.
module pfg_irq #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] latch_d,
  output logic           irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |latch_d;
  end
endmodule

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] flt_lvl,
  input  logic [NCH-1:0] flt_rise,
  input  logic           period_start,
  input  logic           reg_wr,
  input  logic [1:0]     reg_sel,
  input  logic [NCH-1:0] reg_wdata,
  output logic [NCH-1:0] pwm_dis,
  output logic [NCH-1:0] lvl_rd,
  output logic [NCH-1:0] flag_rd,
  output logic [NCH-1:0] ien_rd,
  output logic           irq
);
  logic [NCH-1:0] ack_vec;
  logic [NCH-1:0] ien_next;
  logic [NCH-1:0] latch_d;
  logic [NCH-1:0] latch_q;

  pfg_regfile #(.NCH(NCH)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_sel   (reg_sel),
    .reg_wdata (reg_wdata),
    .ack_vec   (ack_vec),
    .ien_next  (ien_next),
    .ien_q     (ien_rd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    pfg_chan u_chan (
      .clk          (clk),
      .rst          (rst),
      .lvl          (flt_lvl[i]),
      .rise         (flt_rise[i]),
      .period_start (period_start),
      .ack          (ack_vec[i]),
      .ien_next     (ien_next[i]),
      .dis          (pwm_dis[i]),
      .lvl_q        (lvl_rd[i]),
      .flag_q       (flag_rd[i]),
      .latch_d      (latch_d[i]),
      .latch_q      (latch_q[i])
    );
  end

  pfg_irq #(.NCH(NCH)) u_irq (
    .clk     (clk),
    .rst     (rst),
    .latch_d (latch_d),
    .irq     (irq)
  );
endmodule

// File: rtl/pwm_fault_guard_chk.sv
module pwm_fault_guard_chk #(
  parameter int NCH = 4
) (
  input logic           clk,
  input logic           rst,
  input logic [NCH-1:0] flt_lvl,
  input logic [NCH-1:0] flt_rise,
  input logic           period_start,
  input logic           reg_wr,
  input logic [1:0]     reg_sel,
  input logic [NCH-1:0] reg_wdata,
  input logic [NCH-1:0] pwm_dis,
  input logic [NCH-1:0] lvl_rd,
  input logic [NCH-1:0] flag_rd,
  input logic [NCH-1:0] ien_rd,
  input logic           irq
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    p_dis_on_fault_r1: assert property (@(posedge clk) disable iff (rst)
      flt_lvl[i] |-> pwm_dis[i]);

    p_release_at_period_r2: assert property (@(posedge clk) disable iff (rst)
      $fell(pwm_dis[i]) |-> ($past(period_start) && !$past(flt_lvl[i])));

    p_hold_without_period_r3: assert property (@(posedge clk) disable iff (rst)
      (pwm_dis[i] && !period_start) |=> pwm_dis[i]);

    p_flag_sets_r5: assert property (@(posedge clk) disable iff (rst)
      flt_rise[i] |=> flag_rd[i]);

    p_flag_kept_on_clash_r6: assert property (@(posedge clk) disable iff (rst)
      (flt_rise[i] && reg_wr && reg_sel == 2'd0 && reg_wdata[i]) |=> flag_rd[i]);
  end

  p_level_mirror_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (lvl_rd == $past(flt_lvl)));

  // R7 and R8: a pending request needs an enabled, still-flagged channel
  p_irq_backed_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> ((flag_rd & ien_rd) != '0));

  p_reset_clears_r9: assert property (@(posedge clk)
    $past(rst) |-> (!irq && flag_rd == '0 && ien_rd == '0));
endmodule

bind pwm_fault_guard pwm_fault_guard_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/pwm_fault_guard_tb.sv
`timescale 1ns/1ps
module pwm_fault_guard_tb;
  localparam int NCH = 4;

  typedef struct packed {
    logic [NCH-1:0] dis;
    logic [NCH-1:0] lvl;
    logic [NCH-1:0] flag;
    logic [NCH-1:0] ien;
    logic           irq;
  } obs_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [NCH-1:0] flt_lvl = '0;
  logic [NCH-1:0] flt_rise = '0;
  logic           period_start = 1'b0;
  logic           reg_wr = 1'b0;
  logic [1:0]     reg_sel = 2'd0;
  logic [NCH-1:0] reg_wdata = '0;
  logic [NCH-1:0] pwm_dis, lvl_rd, flag_rd, ien_rd;
  logic           irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  obs_t  exp_q[$];
  string tag_q[$];

  // reference state
  logic [NCH-1:0] m_hold = '0, m_flag = '0, m_ien = '0, m_latch = '0;

  always #10 clk = ~clk;

  pwm_fault_guard #(.NCH(NCH)) u_dut (.*);

  function automatic obs_t now_obs();
    obs_t o;
    o.dis = pwm_dis; o.lvl = lvl_rd; o.flag = flag_rd; o.ien = ien_rd; o.irq = irq;
    return o;
  endfunction

  task automatic cmp(string tag, obs_t act, obs_t exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act dis=%b lvl=%b flag=%b ien=%b irq=%b exp dis=%b lvl=%b flag=%b ien=%b irq=%b",
               tag, act.dis, act.lvl, act.flag, act.ien, act.irq,
               exp.dis, exp.lvl, exp.flag, exp.ien, exp.irq);
    end
  endtask

  // driver: apply one cycle of stimulus and queue the expected outcome
  task automatic step(string tag, logic [NCH-1:0] lvl, logic [NCH-1:0] rise, logic ps,
                      logic wr, logic [1:0] sel, logic [NCH-1:0] wd);
    logic [NCH-1:0] ack, ienn;
    obs_t e;
    @(negedge clk);
    flt_lvl = lvl; flt_rise = rise; period_start = ps;
    reg_wr = wr; reg_sel = sel; reg_wdata = wd;
    ack  = (wr && sel == 2'd0) ? wd : '0;
    ienn = (wr && sel == 2'd1) ? wd : m_ien;
    m_flag  = rise | (m_flag & ~ack);
    m_latch = (rise & ienn) | (m_latch & ~ack & ienn);
    m_hold  = lvl | (m_hold & ~{NCH{ps}});
    m_ien   = ienn;
    e.dis = lvl | m_hold; e.lvl = lvl; e.flag = m_flag; e.ien = m_ien; e.irq = |m_latch;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic idle(string tag);
    step(tag, '0, '0, 1'b0, 1'b0, 2'd0, '0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; flt_lvl = '0; flt_rise = '0; period_start = 1'b0; reg_wr = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    m_hold = '0; m_flag = '0; m_ien = '0; m_latch = '0;
    #1;
    cmp("R9 reset state", now_obs(), '0);
  endtask

  // monitor: compare after each edge, while inputs are still steady
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) cmp(tag_q.pop_front(), now_obs(), exp_q.pop_front());
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1;
    cmp("R9 initial reset state", now_obs(), '0);

    step("R1 R5 fault on ch0", 4'b0001, 4'b0001, 1'b0, 1'b0, 2'd0, '0);
    #1;
    total++;
    if (pwm_dis[0] !== 1'b1) begin
      bad++;
      $display("FAIL R1 same-cycle disable act=%b exp=1", pwm_dis[0]);
    end
    step("R5 flag holds", 4'b0001, 4'b0000, 1'b0, 1'b0, 2'd0, '0);
    step("R2 hold after fault falls", 4'b0000, '0, 1'b0, 1'b0, 2'd0, '0);
    step("R3 R5 ack keeps disable", 4'b0000, '0, 1'b0, 1'b1, 2'd0, 4'b0001);
    step("R2 period start releases", 4'b0000, '0, 1'b1, 1'b0, 2'd0, '0);
    idle("R2 released");
    step("R3 ack while fault high", 4'b0011, 4'b0011, 1'b0, 1'b0, 2'd0, '0);
    step("R3 ack no release", 4'b0011, '0, 1'b0, 1'b1, 2'd0, 4'b0011);
    step("R2 period while fault high", 4'b0011, '0, 1'b1, 1'b0, 2'd0, '0);
    step("R2 fault low no period", 4'b0000, '0, 1'b0, 1'b0, 2'd0, '0);
    step("R2 release both", 4'b0000, '0, 1'b1, 1'b0, 2'd0, '0);
    step("R7 enable write", 4'b0000, '0, 1'b0, 1'b1, 2'd1, 4'b0110);
    step("R7 edge raises irq", 4'b0010, 4'b0010, 1'b0, 1'b0, 2'd0, '0);
    step("R4 level write ignored", 4'b0000, '0, 1'b1, 1'b1, 2'd2, 4'b1111);
    step("R4 reserved write ignored", 4'b0000, '0, 1'b0, 1'b1, 2'd3, 4'b1111);
    step("R6 ack with new edge", 4'b0000, 4'b0010, 1'b0, 1'b1, 2'd0, 4'b0010);
    step("R8 ack clears latch", 4'b0000, '0, 1'b0, 1'b1, 2'd0, 4'b0010);
    step("R7 edge ch2", 4'b0100, 4'b0100, 1'b0, 1'b0, 2'd0, '0);
    step("R8 enable clear keeps flag", 4'b0000, '0, 1'b1, 1'b1, 2'd1, 4'b0010);
    step("R5 zero ack no effect", 4'b0000, '0, 1'b0, 1'b1, 2'd0, 4'b0000);
    step("R7 edge while disabled", 4'b0000, 4'b1000, 1'b0, 1'b0, 2'd0, '0);
    step("R7 enable ch3", 4'b0000, '0, 1'b0, 1'b1, 2'd1, 4'b1000);
    step("R7 edge write-through enable", 4'b0000, 4'b0001, 1'b0, 1'b1, 2'd1, 4'b1001);
    step("R7 edge ch3 enabled", 4'b1000, 4'b1000, 1'b0, 1'b0, 2'd0, '0);
    idle("R2 held for ch3");
    wait (exp_q.size() == 0);
    @(posedge clk); #6;
    do_reset();
    idle("R9 quiet after reset");
    wait (exp_q.size() == 0);
    @(posedge clk); #6;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule